// File: doc/BRIEF.md
# Stacked-Sensor Column Coincidence Filter

The filter takes two hit lists that describe the same time stamp: one from the inner layer of a stacked pixel sensor pair and one from the outer layer. Each list arrives on its own valid/ready stream. The list opens with a stamp word, carries column addresses sorted from the lowest column upward, and closes with an end word. The block walks both lists in step, in the way a merge of two sorted lists does. It throws away any hit that has no partner within the search window in the other layer.

The search window is plus or minus one column by default. Every inner/outer pair that falls inside the window goes out on a single output stream, tagged with the event stamp. The last word of the event carries the stamp and is marked as the end of the event. If the two stamps disagree, the block raises a one-cycle error pulse and drains both lists without producing any output. It then waits for the next event.

Top module: `stack_coinc_filter`

## Requirements
- R1: After reset, out_valid and stamp_err are low, and inr_ready and otr_ready are both high while the block waits for stamp words.
- R2: Each input word carries a kind code: 2'b00 for a stamp (the stamp sits in the low TS_W bits of data), 2'b01 for a hit (the column sits in the low COL_W bits), and 2'b10 for the end of the list. Every output word of an event carries that event's stamp on out_stamp.
- R3: While both lists hold a hit, if the outer column is greater than the inner column plus WIN, the inner hit is discarded and produces no output.
- R4: While both lists hold a hit, if the outer column plus WIN is less than the inner column, the outer hit is discarded and produces no output.
- R5: Otherwise the pair is emitted with out_last=0, out_inner set to the inner column and out_outer set to the outer column. Only the inner list advances, so one outer hit can pair with several neighbouring inner hits. Within an event, the inner columns of successive pairs never decrease.
- R6: The window comparison does not wrap. Columns 0 and 2^COL_W-1 are compared as plain unsigned numbers.
- R7: Once either list reaches its end word, the remaining hits of the other list are discarded. One end-of-event word follows the last pair, with out_last=1, both columns 0, and the event stamp.
- R8: If the two stamps differ, stamp_err is high for exactly one cycle. Both lists are consumed up to their end words, and no output word is produced for that event.
- R9: While out_valid is high and out_ready is low, out_valid and all output fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inr_valid | input | 1 | Inner list word valid |
| inr_ready | output | 1 | Inner list word accepted |
| inr_kind | input | 2 | Inner word kind code |
| inr_data | input | DATA_W | Inner stamp or column |
| otr_valid | input | 1 | Outer list word valid |
| otr_ready | output | 1 | Outer list word accepted |
| otr_kind | input | 2 | Outer word kind code |
| otr_data | input | DATA_W | Outer stamp or column |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_last | output | 1 | End-of-event word marker |
| out_stamp | output | TS_W | Event stamp |
| out_inner | output | COL_W | Inner column of pair |
| out_outer | output | COL_W | Outer column of pair |
| stamp_err | output | 1 | One-cycle stamp mismatch pulse |

## Verification
The bench builds the block with COL_W=8, TS_W=8 and WIN=1. With these values the top column 255 and the bottom column 0 can both be reached with short lists, which exercises the non-wrapping comparison at both ends of the range. The 8-bit stamp lets events at stamp 0 and stamp 255 be checked for correct tagging. A window of one puts columns that differ by exactly one on the matching side and columns that differ by two on the discard side, so a single event can exercise both outcomes of the comparison at its edge.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  typedef enum logic [1:0] {
    K_STAMP = 2'b00,
    K_HIT   = 2'b01,
    K_END   = 2'b10,
    K_RSVD  = 2'b11
  } word_kind_e;

  typedef enum logic [1:0] {
    V_DROP_INR = 2'b00,
    V_DROP_OTR = 2'b01,
    V_PAIR     = 2'b10
  } verdict_e;

  typedef enum logic [1:0] {
    PH_STAMP = 2'b00,
    PH_MERGE = 2'b01,
    PH_FLUSH = 2'b10,
    PH_TAIL  = 2'b11
  } phase_e;
endpackage

// File: rtl/ccf_rst_sync.sv
module ccf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ccf_window_cmp.sv
module ccf_window_cmp
  import ccf_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int WIN   = 1
) (
  input  logic [COL_W-1:0] inr_col,
  input  logic [COL_W-1:0] otr_col,
  output verdict_e         verdict
);
  localparam int EW = COL_W + $clog2(WIN + 2);
  localparam logic [EW-1:0] WIN_EXT = EW'(WIN);

  logic [EW-1:0] i_ext;
  logic [EW-1:0] o_ext;

  always_comb begin
    i_ext = EW'(inr_col);
    o_ext = EW'(otr_col);
    if (o_ext > i_ext + WIN_EXT)      verdict = V_DROP_INR;
    else if (o_ext + WIN_EXT < i_ext) verdict = V_DROP_OTR;
    else                              verdict = V_PAIR;
  end
endmodule

// File: rtl/ccf_out_slot.sv
module ccf_out_slot #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         take,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         free
);
  logic         valid_q;
  logic         valid_d;
  logic [W-1:0] data_q;

  assign free  = !valid_q || take;
  assign valid = valid_q;
  assign dout  = data_q;

  always_comb begin
    valid_d = valid_q;
    if (load)      valid_d = 1'b1;
    else if (take) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load) data_q <= din;
  end
endmodule

// File: rtl/stack_coinc_filter.sv
module stack_coinc_filter
  import ccf_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int TS_W  = 8,
  parameter int WIN   = 1,
  localparam int DATA_W = (COL_W > TS_W) ? COL_W : TS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inr_valid,
  output logic              inr_ready,
  input  logic [1:0]        inr_kind,
  input  logic [DATA_W-1:0] inr_data,
  input  logic              otr_valid,
  output logic              otr_ready,
  input  logic [1:0]        otr_kind,
  input  logic [DATA_W-1:0] otr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last,
  output logic [TS_W-1:0]   out_stamp,
  output logic [COL_W-1:0]  out_inner,
  output logic [COL_W-1:0]  out_outer,
  output logic              stamp_err
);
  localparam int SW = 1 + TS_W + 2 * COL_W;

  logic rst_i_n;

  ccf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  phase_e          phase_q, phase_d;
  logic [TS_W-1:0] inr_stamp_q, inr_stamp_d;
  logic [TS_W-1:0] otr_stamp_q, otr_stamp_d;
  logic [TS_W-1:0] stamp_q, stamp_d;
  logic            inr_has_q, inr_has_d;
  logic            otr_has_q, otr_has_d;
  logic            inr_done_q, inr_done_d;
  logic            otr_done_q, otr_done_d;
  logic            flush_err_q, flush_err_d;
  logic            err_q, err_d;

  logic            slot_load;
  logic            slot_last;
  logic            slot_free;
  logic [SW-1:0]   slot_din;
  logic [SW-1:0]   slot_dout;
  verdict_e        verdict;

  ccf_window_cmp #(.COL_W(COL_W), .WIN(WIN)) u_cmp (
    .inr_col(inr_data[COL_W-1:0]),
    .otr_col(otr_data[COL_W-1:0]),
    .verdict(verdict)
  );

  always_comb begin
    phase_d     = phase_q;
    inr_stamp_d = inr_stamp_q;
    otr_stamp_d = otr_stamp_q;
    stamp_d     = stamp_q;
    inr_has_d   = inr_has_q;
    otr_has_d   = otr_has_q;
    inr_done_d  = inr_done_q;
    otr_done_d  = otr_done_q;
    flush_err_d = flush_err_q;
    err_d       = 1'b0;
    inr_ready   = 1'b0;
    otr_ready   = 1'b0;
    slot_load   = 1'b0;
    slot_last   = 1'b0;

    unique case (phase_q)
      PH_STAMP: begin
        inr_ready = !inr_has_q;
        otr_ready = !otr_has_q;
        if (inr_valid && inr_ready && inr_kind == K_STAMP) begin
          inr_has_d   = 1'b1;
          inr_stamp_d = inr_data[TS_W-1:0];
        end
        if (otr_valid && otr_ready && otr_kind == K_STAMP) begin
          otr_has_d   = 1'b1;
          otr_stamp_d = otr_data[TS_W-1:0];
        end
        if (inr_has_d && otr_has_d) begin
          inr_has_d  = 1'b0;
          otr_has_d  = 1'b0;
          inr_done_d = 1'b0;
          otr_done_d = 1'b0;
          if (inr_stamp_d == otr_stamp_d) begin
            stamp_d     = inr_stamp_d;
            flush_err_d = 1'b0;
            phase_d     = PH_MERGE;
          end else begin
            err_d       = 1'b1;
            flush_err_d = 1'b1;
            phase_d     = PH_FLUSH;
          end
        end
      end
      PH_MERGE: begin
        if (inr_valid && inr_kind == K_END) begin
          inr_ready  = 1'b1;
          inr_done_d = 1'b1;
          phase_d    = PH_FLUSH;
        end else if (otr_valid && otr_kind == K_END) begin
          otr_ready  = 1'b1;
          otr_done_d = 1'b1;
          phase_d    = PH_FLUSH;
        end else if (inr_valid && otr_valid) begin
          unique case (verdict)
            V_DROP_INR: inr_ready = 1'b1;
            V_DROP_OTR: otr_ready = 1'b1;
            V_PAIR: begin
              if (slot_free) begin
                inr_ready = 1'b1;
                slot_load = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      PH_FLUSH: begin
        inr_ready = !inr_done_q;
        otr_ready = !otr_done_q;
        if (inr_valid && inr_ready && inr_kind == K_END) inr_done_d = 1'b1;
        if (otr_valid && otr_ready && otr_kind == K_END) otr_done_d = 1'b1;
        if (inr_done_d && otr_done_d) begin
          phase_d = flush_err_q ? PH_STAMP : PH_TAIL;
        end
      end
      PH_TAIL: begin
        if (slot_free) begin
          slot_load = 1'b1;
          slot_last = 1'b1;
          phase_d   = PH_STAMP;
        end
      end
      default: phase_d = PH_STAMP;
    endcase
  end

  always_comb begin
    if (slot_last) slot_din = {1'b1, stamp_q, {(2 * COL_W){1'b0}}};
    else           slot_din = {1'b0, stamp_q, inr_data[COL_W-1:0], otr_data[COL_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      phase_q     <= PH_STAMP;
      inr_has_q   <= 1'b0;
      otr_has_q   <= 1'b0;
      inr_done_q  <= 1'b0;
      otr_done_q  <= 1'b0;
      flush_err_q <= 1'b0;
      err_q       <= 1'b0;
      inr_stamp_q <= '0;
      otr_stamp_q <= '0;
      stamp_q     <= '0;
    end else begin
      phase_q     <= phase_d;
      inr_has_q   <= inr_has_d;
      otr_has_q   <= otr_has_d;
      inr_done_q  <= inr_done_d;
      otr_done_q  <= otr_done_d;
      flush_err_q <= flush_err_d;
      err_q       <= err_d;
      inr_stamp_q <= inr_stamp_d;
      otr_stamp_q <= otr_stamp_d;
      stamp_q     <= stamp_d;
    end
  end

  ccf_out_slot #(.W(SW)) u_slot (
    .clk(clk), .rst_n(rst_i_n),
    .load(slot_load), .din(slot_din), .take(out_ready),
    .valid(out_valid), .dout(slot_dout), .free(slot_free)
  );

  assign out_last  = slot_dout[SW-1];
  assign out_stamp = slot_dout[SW-2 -: TS_W];
  assign out_inner = slot_dout[2*COL_W-1 -: COL_W];
  assign out_outer = slot_dout[COL_W-1:0];
  assign stamp_err = err_q;
endmodule

// File: rtl/ccf_chk.sv
module ccf_chk #(
  parameter int COL_W = 8,
  parameter int TS_W  = 8,
  parameter int WIN   = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_last,
  input logic [TS_W-1:0]  out_stamp,
  input logic [COL_W-1:0] out_inner,
  input logic [COL_W-1:0] out_outer,
  input logic             stamp_err
);
  localparam int EW = COL_W + $clog2(WIN + 2);

  logic [EW-1:0]    in_x;
  logic [EW-1:0]    ou_x;
  logic [COL_W-1:0] prev_inner;
  logic             have_prev;

  assign in_x = EW'(out_inner);
  assign ou_x = EW'(out_outer);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev  <= 1'b0;
      prev_inner <= '0;
    end else if (out_valid && out_ready) begin
      have_prev  <= !out_last;
      prev_inner <= out_inner;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_last) && $stable(out_stamp)
                                && $stable(out_inner) && $stable(out_outer));

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_err |=> !stamp_err);

  // R6
  pair_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> (ou_x <= in_x + EW'(WIN)) && (in_x <= ou_x + EW'(WIN)));

  // R5
  inner_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last && have_prev |-> out_inner >= prev_inner);
endmodule

bind stack_coinc_filter ccf_chk #(.COL_W(COL_W), .TS_W(TS_W), .WIN(WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_last(out_last), .out_stamp(out_stamp), .out_inner(out_inner),
  .out_outer(out_outer), .stamp_err(stamp_err)
);

// File: tb/tb_stack_coinc_filter.sv
module tb_stack_coinc_filter;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] KS = 2'b00, KH = 2'b01, KE = 2'b10;

  typedef struct packed {
    logic [7:0]      ts_i;
    logic [7:0]      ts_o;
    logic [2:0]      ni;
    logic [3:0][7:0] ci;
    logic [2:0]      no;
    logic [3:0][7:0] co;
    logic [2:0]      npair;
    logic            err;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'd5,   8'd5,   3'd3, {8'd0, 8'd30, 8'd20, 8'd10},   3'd3, {8'd0, 8'd29, 8'd20, 8'd11}, 3'd3, 1'b0},
    '{8'd7,   8'd7,   3'd3, {8'd0, 8'd5, 8'd4, 8'd3},      3'd1, {8'd0, 8'd0, 8'd0, 8'd4},    3'd3, 1'b0},
    '{8'd12,  8'd12,  3'd2, {8'd0, 8'd0, 8'd50, 8'd0},     3'd2, {8'd0, 8'd0, 8'd48, 8'd2},   3'd0, 1'b0},
    '{8'd200, 8'd200, 3'd2, {8'd0, 8'd0, 8'd255, 8'd254},  3'd1, {8'd0, 8'd0, 8'd0, 8'd255},  3'd2, 1'b0},
    '{8'd1,   8'd1,   3'd0, {8'd0, 8'd0, 8'd0, 8'd0},      3'd2, {8'd0, 8'd0, 8'd2, 8'd1},    3'd0, 1'b0},
    '{8'd9,   8'd10,  3'd1, {8'd0, 8'd0, 8'd0, 8'd1},      3'd1, {8'd0, 8'd0, 8'd0, 8'd1},    3'd0, 1'b1},
    '{8'd3,   8'd3,   3'd4, {8'd4, 8'd3, 8'd2, 8'd1},      3'd0, {8'd0, 8'd0, 8'd0, 8'd0},    3'd0, 1'b0},
    '{8'd0,   8'd0,   3'd2, {8'd0, 8'd0, 8'd5, 8'd0},      3'd2, {8'd0, 8'd0, 8'd7, 8'd1},    3'd1, 1'b0},
    '{8'd255, 8'd255, 3'd1, {8'd0, 8'd0, 8'd0, 8'd100},    3'd2, {8'd0, 8'd0, 8'd102, 8'd101},3'd1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       inr_valid, otr_valid, out_ready;
  logic       inr_ready, otr_ready;
  logic [1:0] inr_kind, otr_kind;
  logic [7:0] inr_data, otr_data;
  logic       out_valid, out_last, stamp_err;
  logic [7:0] out_stamp, out_inner, out_outer;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stack_coinc_filter dut (
    .clk(clk), .rst_n(rst_n),
    .inr_valid(inr_valid), .inr_ready(inr_ready), .inr_kind(inr_kind), .inr_data(inr_data),
    .otr_valid(otr_valid), .otr_ready(otr_ready), .otr_kind(otr_kind), .otr_data(otr_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .out_stamp(out_stamp), .out_inner(out_inner), .out_outer(out_outer),
    .stamp_err(stamp_err)
  );

  int   checks = 0, failures = 0;
  bit   finished = 0;
  bit   hold_low = 0;
  int   rp_cnt = 0;
  int   got_n = 0, err_seen = 0;
  logic       got_last [16];
  logic [7:0] got_ts [16], got_i [16], got_o [16];
  int   exp_n;
  int   exp_i [8], exp_o [8];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // output monitor with a ready pattern
  initial begin
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      rp_cnt++;
      out_ready = hold_low ? 1'b0 : ((rp_cnt % 3) != 2);
      #1;
      if (out_valid && out_ready && got_n < 16) begin
        got_last[got_n] = out_last;
        got_ts[got_n]   = out_stamp;
        got_i[got_n]    = out_inner;
        got_o[got_n]    = out_outer;
        got_n++;
      end
      if (stamp_err) err_seen++;
    end
  end

  task automatic send_inr(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk);
    inr_valid = 1'b1; inr_kind = k; inr_data = d;
    forever begin
      #1;
      if (inr_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
  endtask

  task automatic send_otr(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk);
    otr_valid = 1'b1; otr_kind = k; otr_data = d;
    forever begin
      #1;
      if (otr_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
  endtask

  task automatic list_inr(input vec_t v);
    send_inr(KS, v.ts_i);
    for (int k = 0; k < int'(v.ni); k++) send_inr(KH, v.ci[k]);
    send_inr(KE, 8'd0);
    @(negedge clk); inr_valid = 1'b0;
  endtask

  task automatic list_otr(input vec_t v);
    send_otr(KS, v.ts_o);
    for (int k = 0; k < int'(v.no); k++) send_otr(KH, v.co[k]);
    send_otr(KE, 8'd0);
    @(negedge clk); otr_valid = 1'b0;
  endtask

  // behavioural model of the requirements
  task automatic build_exp(input vec_t v);
    int i = 0, j = 0, a, b;
    exp_n = 0;
    if (v.ts_i != v.ts_o) return;
    while (i < int'(v.ni) && j < int'(v.no)) begin
      a = int'(v.ci[i]); b = int'(v.co[j]);
      if (b > a + 1) i++;
      else if (b + 1 < a) j++;
      else begin exp_i[exp_n] = a; exp_o[exp_n] = b; exp_n++; i++; end
    end
  endtask

  task automatic run_event(input vec_t v);
    got_n = 0; err_seen = 0;
    fork
      list_inr(v);
      list_otr(v);
    join
    repeat (8) @(negedge clk);
  endtask

  task automatic check_event(input vec_t v, input int e);
    int pairs = 0;
    build_exp(v);
    for (int k = 0; k < got_n; k++) if (!got_last[k]) pairs++;
    chk(pairs == int'(v.npair) && pairs == exp_n, $sformatf("R3 R4 R5 pair count event %0d", e),
        pairs, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++)
      chk(got_i[k] == exp_i[k][7:0] && got_o[k] == exp_o[k][7:0] && got_ts[k] == v.ts_i && !got_last[k],
          $sformatf("R2 R5 R6 pair %0d event %0d", k, e),
          int'({got_ts[k], got_i[k], got_o[k]}), int'({v.ts_i, exp_i[k][7:0], exp_o[k][7:0]}));
    if (v.err)
      chk(got_n == 0, $sformatf("R8 no output on stamp mismatch event %0d", e), got_n, 0);
    else
      chk(got_n == exp_n + 1 && got_last[exp_n] && got_ts[exp_n] == v.ts_i
          && got_i[exp_n] == 0 && got_o[exp_n] == 0,
          $sformatf("R7 R2 end-of-event word event %0d", e), got_n, exp_n + 1);
    chk(err_seen == int'(v.err), $sformatf("R8 stamp_err cycles event %0d", e), err_seen, int'(v.err));
  endtask

  initial begin
    vec_t bp;
    rst_n = 1'b0;
    inr_valid = 1'b0; otr_valid = 1'b0;
    inr_kind = KS; otr_kind = KS; inr_data = '0; otr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(stamp_err == 1'b0, "R1 stamp_err after reset", stamp_err, 0);
    chk(inr_ready == 1'b1, "R1 inr_ready idle", inr_ready, 1);
    chk(otr_ready == 1'b1, "R1 otr_ready idle", otr_ready, 1);

    for (int e = 0; e < NV; e++) begin
      run_event(VEC[e]);
      check_event(VEC[e], e);
    end

    // R9: output held under backpressure
    bp = '{8'd42, 8'd42, 3'd1, {8'd0, 8'd0, 8'd0, 8'd10}, 3'd1, {8'd0, 8'd0, 8'd0, 8'd10}, 3'd1, 1'b0};
    hold_low = 1'b1;
    got_n = 0; err_seen = 0;
    fork
      list_inr(bp);
      list_otr(bp);
    join
    repeat (5) @(negedge clk);
    #2;
    chk(out_valid == 1'b1, "R9 out_valid held", out_valid, 1);
    chk(out_inner == 8'd10 && out_outer == 8'd10 && !out_last && out_stamp == 8'd42,
        "R9 pair held", int'({out_stamp, out_inner, out_outer}), int'({8'd42, 8'd10, 8'd10}));
    hold_low = 1'b0;
    repeat (8) @(negedge clk);
    check_event(bp, NV);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule